// File: doc/BRIEF.md
# Pixel Fast-Switch Overlay Mixer

This block sits at the end of a video decoder's pixel path and produces one YCbCr pixel per pixel period. It chooses from three sources, or blends between them: the decoded main video (composite or S-Video, with component as a separate input), an analog SCART RGB path that reaches the block already converted to YCbCr, and a 3-bit digital RGB overlay that selects one of eight colours. Two fast-switch control lines drive the choice. They come from asynchronous sources, so the block resynchronises each one and samples it on every edge of a clock that runs at four times the pixel rate. The number of high samples in a pixel period sets the mix weight, which softens overlay edges that fall inside a pixel.

A 3-bit mode input picks one of eight switching topologies. These range from a plain two-way choice, through nested three-way blends, to pass-through. Per-pixel delay lines move the component, SCART and overlay paths and the overlay switch count into line with the main video before mixing.

Top module: `fsw_overlay_mixer`

## Requirements
- R1: While rst_n is low, out_ycc is 0 and out_vld is 0.
- R2: Rising edges are numbered from the first edge with rst_n high, as edge 0. out_vld is high for exactly the one cycle after edge 4p+4 for every pixel p >= 0, and out_ycc changes only at those edges.
- R3: Each switch control passes through two resynchronising flops. The count n for pixel p is the number of ones among that control's values at edges 4p-3 to 4p. A value before edge 0 counts as 0.
- R4: A blend of source A against source B with count n gives floor((n*A + (4-n)*B + 2)/4) in each 10-bit lane. A is the source that wins when the control is high.
- R5: Mode 0 blends SCART (A) against main video by the SCART count. Mode 1 blends the overlay (A) against main video, and mode 2 blends the overlay (A) against component, both by the overlay count.
- R6: Mode 3 blends the overlay over the mode-0 result by the overlay count. Mode 4 blends SCART over (overlay blended over main video by the overlay count), using the SCART count. Mode 5 blends (overlay over SCART by the overlay count) against main video, using the SCART count. Each inner blend is rounded before the outer one.
- R7: Mode 6 outputs main video unchanged. Mode 7 outputs the delayed component path unchanged.
- R8: ovl_rgb bit 2 is red, bit 1 is green and bit 0 is blue. The colour maps to Y=64+262R+514G+100B, Cb=512-151R-297G+448B, Cr=512+448R-375G-73B. out_ycc and every input carry Y in bits 29:20, Cb in bits 19:10 and Cr in bits 9:0.
- R9: dly_comp, dly_scart and dly_ovl delay their data paths by that many pixels, and dly_ovl_fs delays the overlay count in the same way. Main video and the SCART count are not delayed. Pixels from before reset read as zero.
- R10: Pixel data is taken at edge 4p+3. The mode and delay inputs are taken at edge 4p+4, and the result appears on out_ycc after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 4x pixel-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 3 | Switching topology |
| fs_scart | input | 1 | Asynchronous SCART fast-switch control |
| fs_ovl | input | 1 | Asynchronous overlay fast-switch control |
| dly_comp | input | DLY_W | Component path delay in pixels |
| dly_scart | input | DLY_W | SCART path delay in pixels |
| dly_ovl | input | DLY_W | Overlay colour delay in pixels |
| dly_ovl_fs | input | DLY_W | Overlay switch count delay in pixels |
| cvbs_ycc | input | 3*DW | Main (composite/S-Video) pixel |
| comp_ycc | input | 3*DW | Component pixel |
| scart_ycc | input | 3*DW | SCART pixel, already YCbCr |
| ovl_rgb | input | 3 | Digital overlay colour bits |
| out_ycc | output | 3*DW | Mixed pixel |
| out_vld | output | 1 | One-cycle strobe marking a new pixel |

## Verification
Controls held at all ones and all zeros confirm that each topology picks its sources purely. Fixed periodic patterns such as one high sample in four, or two or three in four, set the intermediate weights and expose the rounding. Random per-edge control bits with random data, modes and delays separate the SCART count from the overlay count and the inner blend from the outer one. A directed walk through all eight overlay colours at full weight pins down the colour table, and maximum delays with changing data show whether each tap is aligned.

// File: rtl/fsw_overlay_mixer.sv
module fsw_overlay_mixer #(
  parameter int DW    = 10,
  parameter int DLY_W = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2:0]          mode,
  input  logic                fs_scart,
  input  logic                fs_ovl,
  input  logic [DLY_W-1:0]    dly_comp,
  input  logic [DLY_W-1:0]    dly_scart,
  input  logic [DLY_W-1:0]    dly_ovl,
  input  logic [DLY_W-1:0]    dly_ovl_fs,
  input  logic [3*DW-1:0]     cvbs_ycc,
  input  logic [3*DW-1:0]     comp_ycc,
  input  logic [3*DW-1:0]     scart_ycc,
  input  logic [2:0]          ovl_rgb,
  output logic [3*DW-1:0]     out_ycc,
  output logic                out_vld
);

  localparam int PW    = 3 * DW;
  localparam int DEPTH = 1 << DLY_W;
  localparam int SH    = DW - 10;

  function automatic logic [PW-1:0] ovl_lut(input logic [2:0] c);
    int r, g, b, y, cb, cr;
    r  = int'(c[2]);
    g  = int'(c[1]);
    b  = int'(c[0]);
    y  = 64  + 262 * r + 514 * g + 100 * b;
    cb = 512 - 151 * r - 297 * g + 448 * b;
    cr = 512 + 448 * r - 375 * g - 73 * b;
    return {DW'(y << SH), DW'(cb << SH), DW'(cr << SH)};
  endfunction

  function automatic logic [PW-1:0] blend(input logic [PW-1:0] a,
                                           input logic [PW-1:0] b,
                                           input logic [2:0] n);
    logic [PW-1:0] o;
    int s;
    for (int l = 0; l < 3; l++) begin
      s = int'(n) * int'(a[l*DW +: DW]) + (4 - int'(n)) * int'(b[l*DW +: DW]) + 2;
      o[l*DW +: DW] = DW'(s >> 2);
    end
    return o;
  endfunction

  logic [1:0]      fs_in;
  logic [1:0][2:0] cnt;
  assign fs_in = {fs_ovl, fs_scart};

  for (genvar g = 0; g < 2; g++) begin : g_fs
    logic       s1, s2;
    logic [3:0] win;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        s1  <= 1'b0;
        s2  <= 1'b0;
        win <= '0;
      end else begin
        s1  <= fs_in[g];
        s2  <= s1;
        win <= {win[2:0], s2};
      end
    end
    assign cnt[g] = 3'($countones(win));
  end

  logic [1:0] ph;
  logic       cap, ld;
  assign cap = (ph == 2'd3);

  logic [PW-1:0] cvbs_q;
  logic [2:0]    n1_q;
  logic [PW-1:0] comp_dl  [DEPTH];
  logic [PW-1:0] scart_dl [DEPTH];
  logic [2:0]    ovl_dl   [DEPTH];
  logic [2:0]    n2_dl    [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph     <= '0;
      ld     <= 1'b0;
      cvbs_q <= '0;
      n1_q   <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        comp_dl[i]  <= '0;
        scart_dl[i] <= '0;
        ovl_dl[i]   <= '0;
        n2_dl[i]    <= '0;
      end
    end else begin
      ph <= ph + 2'd1;
      ld <= cap;
      if (cap) begin
        cvbs_q      <= cvbs_ycc;
        n1_q        <= cnt[0];
        comp_dl[0]  <= comp_ycc;
        scart_dl[0] <= scart_ycc;
        ovl_dl[0]   <= ovl_rgb;
        n2_dl[0]    <= cnt[1];
        for (int i = 1; i < DEPTH; i++) begin
          comp_dl[i]  <= comp_dl[i-1];
          scart_dl[i] <= scart_dl[i-1];
          ovl_dl[i]   <= ovl_dl[i-1];
          n2_dl[i]    <= n2_dl[i-1];
        end
      end
    end
  end

  logic [PW-1:0] co, sc, ov, mix;
  logic [2:0]    k1, k2;
  assign co = comp_dl[dly_comp];
  assign sc = scart_dl[dly_scart];
  assign ov = ovl_lut(ovl_dl[dly_ovl]);
  assign k2 = n2_dl[dly_ovl_fs];
  assign k1 = n1_q;

  always_comb begin
    case (mode)
      3'd0:    mix = blend(sc, cvbs_q, k1);
      3'd1:    mix = blend(ov, cvbs_q, k2);
      3'd2:    mix = blend(ov, co, k2);
      3'd3:    mix = blend(ov, blend(sc, cvbs_q, k1), k2);
      3'd4:    mix = blend(sc, blend(ov, cvbs_q, k2), k1);
      3'd5:    mix = blend(blend(ov, sc, k2), cvbs_q, k1);
      3'd6:    mix = cvbs_q;
      default: mix = co;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_ycc <= '0;
      out_vld <= 1'b0;
    end else begin
      out_vld <= ld;
      if (ld) out_ycc <= mix;
    end
  end

  p_vld_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |=> !out_vld);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !out_vld |-> $stable(out_ycc));

  p_cvbs_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && $past(mode) == 3'd6) |-> out_ycc == $past(cvbs_q));

  p_comp_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && $past(mode) == 3'd7) |-> out_ycc == $past(co));

  p_scart_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && $past(mode) == 3'd0 && $past(k1) == 3'd4) |-> out_ycc == $past(sc));

  p_cvbs_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && $past(mode) == 3'd0 && $past(k1) == 3'd0) |-> out_ycc == $past(cvbs_q));

endmodule

// File: tb/fsw_overlay_mixer_tb.sv
`timescale 1ns/1ps
module fsw_overlay_mixer_tb_top;

  localparam int NE = 8192;
  localparam int NP = 2048;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  mode = '0;
  logic        fs_scart = 1'b0, fs_ovl = 1'b0;
  logic [2:0]  dly_comp = '0, dly_scart = '0, dly_ovl = '0, dly_ovl_fs = '0;
  logic [29:0] cvbs_ycc = '0, comp_ycc = '0, scart_ycc = '0;
  logic [2:0]  ovl_rgb = '0;
  logic [29:0] out_ycc;
  logic        out_vld;

  always #2.5 clk = ~clk;

  fsw_overlay_mixer dut_i (
    .clk(clk), .rst_n(rst_n), .mode(mode), .fs_scart(fs_scart), .fs_ovl(fs_ovl),
    .dly_comp(dly_comp), .dly_scart(dly_scart), .dly_ovl(dly_ovl), .dly_ovl_fs(dly_ovl_fs),
    .cvbs_ycc(cvbs_ycc), .comp_ycc(comp_ycc), .scart_ycc(scart_ycc), .ovl_rgb(ovl_rgb),
    .out_ycc(out_ycc), .out_vld(out_vld)
  );

  int checks = 0, fails = 0;
  int e = 0, edges_done = 0, pix_cnt = 0, ovl_force = -1;
  bit run = 0;

  bit          fs1_h [NE];
  bit          fs2_h [NE];
  logic [29:0] cv_h [NP], co_h [NP], sc_h [NP];
  logic [2:0]  ov_h [NP], md_h [NP], dc_h [NP], ds_h [NP], do_h [NP], df_h [NP];
  string       tag_h [NP];
  string       cur_tag = "R5";

  function automatic logic [29:0] f_lut(input logic [2:0] c);
    int r, g, b;
    r = c[2]; g = c[1]; b = c[0];
    return {10'(64 + 262*r + 514*g + 100*b), 10'(512 - 151*r - 297*g + 448*b),
            10'(512 + 448*r - 375*g - 73*b)};
  endfunction

  function automatic logic [29:0] f_mix(input logic [29:0] a, input logic [29:0] b, input int n);
    logic [29:0] o;
    for (int l = 0; l < 3; l++)
      o[l*10 +: 10] = 10'((n * int'(a[l*10 +: 10]) + (4 - n) * int'(b[l*10 +: 10]) + 2) / 4);
    return o;
  endfunction

  function automatic int f_cnt(input bit which, input int q);
    int s = 0;
    for (int k = 4*q - 3; k <= 4*q; k++)
      if (k >= 0) s += which ? int'(fs2_h[k]) : int'(fs1_h[k]);
    return s;
  endfunction

  function automatic logic [29:0] f_expect(input int q);
    logic [29:0] cv, co, sc, ov;
    int k1, k2, j;
    cv = cv_h[q];
    j = q - int'(dc_h[q]); co = (j >= 0) ? co_h[j] : 30'd0;
    j = q - int'(ds_h[q]); sc = (j >= 0) ? sc_h[j] : 30'd0;
    j = q - int'(do_h[q]); ov = f_lut((j >= 0) ? ov_h[j] : 3'd0);
    j = q - int'(df_h[q]); k2 = (j >= 0) ? f_cnt(1'b1, j) : 0;
    k1 = f_cnt(1'b0, q);
    case (md_h[q])
      3'd0: return f_mix(sc, cv, k1);
      3'd1: return f_mix(ov, cv, k2);
      3'd2: return f_mix(ov, co, k2);
      3'd3: return f_mix(ov, f_mix(sc, cv, k1), k2);
      3'd4: return f_mix(sc, f_mix(ov, cv, k2), k1);
      3'd5: return f_mix(f_mix(ov, sc, k2), cv, k1);
      3'd6: return cv;
      default: return co;
    endcase
  endfunction

  always @(posedge clk) if (rst_n) edges_done <= edges_done + 1;

  // R2 cadence and R4..R10 pixel values
  always @(negedge clk) begin
    if (rst_n && run) begin
      int last;
      bit exp_vld;
      last = edges_done - 1;
      exp_vld = (last >= 4) && (last % 4 == 0);
      checks++;
      if (out_vld !== exp_vld) begin
        fails++;
        $display("FAIL R2 out_vld after edge %0d: actual %0b expected %0b", last, out_vld, exp_vld);
      end
      if (out_vld && pix_cnt < NP) begin
        logic [29:0] ex;
        ex = f_expect(pix_cnt);
        checks++;
        if (out_ycc !== ex) begin
          fails++;
          $display("FAIL R4 R10 %s mode %0d pixel %0d: actual %h expected %h",
                   tag_h[pix_cnt], md_h[pix_cnt], pix_cnt, out_ycc, ex);
        end
        pix_cnt++;
      end
    end
  end

  task automatic step(input bit a, input bit b);
    fs_scart = a;
    fs_ovl   = b;
    fs1_h[e] = a;
    fs2_h[e] = b;
    if (e % 4 == 3) begin
      cv_h[e/4] = cvbs_ycc; co_h[e/4] = comp_ycc; sc_h[e/4] = scart_ycc;
      ov_h[e/4] = ovl_rgb;  tag_h[e/4] = cur_tag;
    end
    if (e % 4 == 0 && e >= 4) begin
      md_h[e/4-1] = mode; dc_h[e/4-1] = dly_comp; ds_h[e/4-1] = dly_scart;
      do_h[e/4-1] = dly_ovl; df_h[e/4-1] = dly_ovl_fs;
    end
    e++;
    @(negedge clk);
  endtask

  task automatic px(input logic [3:0] p1, input logic [3:0] p2);
    cvbs_ycc  = 30'($urandom);
    comp_ycc  = 30'($urandom);
    scart_ycc = 30'($urandom);
    ovl_rgb   = (ovl_force >= 0) ? 3'(ovl_force) : 3'($urandom);
    for (int k = 0; k < 4; k++) step(p1[3-k], p2[3-k]);
  endtask

  task automatic seg(input logic [2:0] m, input logic [3:0] p1, input logic [3:0] p2,
                     input int np, input string t);
    mode = m;
    cur_tag = t;
    for (int i = 0; i < np; i++) px(p1, p2);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (4) @(negedge clk);
    checks++;
    if (out_vld !== 1'b0 || out_ycc !== 30'd0) begin
      fails++;
      $display("FAIL R1 reset: actual vld %0b ycc %h expected 0 0", out_vld, out_ycc);
    end
    rst_n = 1'b1;
    run = 1;
    // R5 R3: pure selections and fixed weights
    seg(3'd0, 4'b1111, 4'b0000, 8, "R5 R3 scart full");
    seg(3'd0, 4'b0000, 4'b1111, 8, "R5 R3 cvbs full");
    seg(3'd0, 4'b1000, 4'b0000, 8, "R5 R3 weight 1/4");
    seg(3'd1, 4'b0000, 4'b1110, 8, "R5 R3 weight 3/4");
    seg(3'd2, 4'b0000, 4'b1100, 8, "R5 R3 weight 1/2");
    // R6 nested topologies
    seg(3'd3, 4'b1100, 4'b1000, 8, "R6 nested");
    seg(3'd4, 4'b1100, 4'b1000, 8, "R6 nested");
    seg(3'd5, 4'b1110, 4'b1100, 8, "R6 nested");
    // R7 pass-through ignores controls
    seg(3'd6, 4'b1111, 4'b1111, 6, "R7 pass");
    seg(3'd7, 4'b1111, 4'b1111, 6, "R7 pass");
    // R8 every overlay colour at full weight
    for (int c = 0; c < 8; c++) begin
      ovl_force = c;
      seg(3'd1, 4'b0000, 4'b1111, 2, "R8 colour");
    end
    ovl_force = -1;
    // R9 maximum and mixed delays
    dly_comp = 3'd7; dly_scart = 3'd7; dly_ovl = 3'd7; dly_ovl_fs = 3'd7;
    seg(3'd2, 4'b0000, 4'b1010, 12, "R9 delay max");
    seg(3'd4, 4'b0110, 4'b0111, 12, "R9 delay max");
    dly_comp = 3'd2; dly_scart = 3'd5; dly_ovl = 3'd1; dly_ovl_fs = 3'd3;
    seg(3'd3, 4'b1010, 4'b0011, 12, "R9 delay mixed");
    // random
    for (int i = 0; i < 400; i++) begin
      if (i % 10 == 0) begin
        mode = 3'($urandom); dly_comp = 3'($urandom); dly_scart = 3'($urandom);
        dly_ovl = 3'($urandom); dly_ovl_fs = 3'($urandom);
      end
      cur_tag = "R3 R5 R6 R9 random";
      px(4'($urandom), 4'($urandom));
    end
    cur_tag = "R10 drain";
    for (int i = 0; i < 3; i++) px(4'b0000, 4'b0000);
    run = 0;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule